// File: doc/BRIEF.md
# SMBus Bus-Ownership Semaphore with Pause Mailbox

This block decides who may drive a shared SMBus controller: the host processor or an embedded microcontroller. The host asks for the bus by writing a request bit in a control register and reads the same bit back. A 1 means the host owns the bus. If the microcontroller is in the middle of a transfer, the request waits and is granted at the microcontroller's next idle point. The host gives the bus up by writing a separate release bit. The microcontroller side is a plain request/grant pair plus an idle strobe.

Before a long transfer, the host can ask the microcontroller to stop its own bus traffic for a while. It does this through a small mailbox, reached by an index port and the data port directly after it. The host clears the response slot, writes a pause-enter or pause-leave code into the flag slot, and then writes the command code. After a fixed latency the block sets the completion code in the response slot and updates the pause output to the microcontroller. While the pause is in effect, the microcontroller is not granted the bus.

Top module: `smbus_sema_arbiter`

## Requirements
- R1: After reset the host does not own the bus, `mcu_gnt` and `mcu_pause` are 0, and every mailbox slot reads 0x00.
- R2: A write to the control register (address 8) with bit 4 set, while the bus is free, gives the bus to the host at that clock edge. Bit 4 of the control register then reads 1.
- R3: A host request made while the microcontroller holds the bus reads back 0 in bit 4. It stays pending until a clock edge where `mcu_idle` is 1 or `mcu_req` is 0. At that edge `mcu_gnt` falls and bit 4 rises.
- R4: A control write with bit 5 set, while the host owns the bus, frees the bus at that edge.
- R5: A release written while the host does not own the bus changes nothing. A request written while the host already owns the bus changes nothing.
- R6: On a free bus with no host request and no pause, `mcu_req` = 1 gives `mcu_gnt` = 1 after one edge. `mcu_gnt` falls at the first edge where `mcu_req` is 0.
- R7: A host request and `mcu_req` that arrive together on a free bus give the bus to the host.
- R8: The mailbox index port is at address 14 and the data port is at address 15. The index port reads back the index. A data access reaches the slot the index selects: 0x80 command, 0x82 response, 0x83 flag. Any other index reads 0x00 and ignores writes.
- R9: Writing command 0x96 makes the response slot read 0xFA exactly RESP_LAT clock edges after the command write. The default RESP_LAT is 4.
- R10: When the command completes, a flag of 0xB4 sets `mcu_pause` to 1 and a flag of 0xB5 clears it. This happens at the same edge as the response.
- R11: A command other than 0x96 is stored but gets no response, and `mcu_pause` is left unchanged.
- R12: While `mcu_pause` is 1, a free bus is never granted to the microcontroller. Host requests are still granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | ADDR_W | Host register address |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data for `reg_addr` (combinational) |
| mcu_req | input | 1 | Microcontroller wants or is using the bus |
| mcu_idle | input | 1 | Microcontroller is at a point where it can hand the bus over |
| mcu_gnt | output | 1 | Microcontroller owns the bus |
| mcu_pause | output | 1 | Microcontroller is asked to pause its bus activity |

## Verification
Ownership is swept over every combination of four factors: the starting owner (free, host, microcontroller), the request and release bits of the control write, `mcu_req`, and `mcu_idle`. This shows whether priority, pending and release rules act correctly in each state. Separate sequences hold a pending request across several busy cycles, and release bits written by a non-owner. The mailbox is driven with the pause-enter flag, the pause-leave flag, a wrong command code and an unmapped index. The response is sampled in each cycle up to the latency, which separates a late or early response from a missing one. Grant attempts by the microcontroller, made while paused and after unpausing, tie the pause back to the arbiter.

// File: rtl/smbus_sema_pkg.sv
package smbus_sema_pkg;

    typedef enum logic [1:0] {
        OWN_FREE = 2'd0,
        OWN_HOST = 2'd1,
        OWN_MCU  = 2'd2
    } own_e;

    // bit positions inside the control register
    localparam int unsigned REQ_BIT = 4;
    localparam int unsigned REL_BIT = 5;

    // mailbox slot indexes
    localparam logic [7:0] SLOT_CMD  = 8'h80;
    localparam logic [7:0] SLOT_RESP = 8'h82;
    localparam logic [7:0] SLOT_FLAG = 8'h83;

    // mailbox code values
    localparam logic [7:0] CODE_CMD_PAUSE = 8'h96;
    localparam logic [7:0] CODE_DONE      = 8'hFA;
    localparam logic [7:0] CODE_ENTER     = 8'hB4;
    localparam logic [7:0] CODE_LEAVE     = 8'hB5;

endpackage

// File: rtl/sema_reg_decode.sv
module sema_reg_decode #(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned CTRL_ADR = 8,
    parameter int unsigned MBX_ADR  = 14
) (
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              host_own,
    input  logic [7:0]        mbx_index,
    input  logic [7:0]        mbx_slot_data,
    output logic              req_wr,
    output logic              rel_wr,
    output logic              idx_wr,
    output logic              dat_wr,
    output logic [7:0]        reg_rdata
);
    import smbus_sema_pkg::*;

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADR);
    localparam logic [ADDR_W-1:0] A_IDX  = ADDR_W'(MBX_ADR);
    localparam logic [ADDR_W-1:0] A_DAT  = ADDR_W'(MBX_ADR + 1);

    logic hit_ctrl, hit_idx, hit_dat;

    always_comb begin
        hit_ctrl = (reg_addr == A_CTRL);
        hit_idx  = (reg_addr == A_IDX);
        hit_dat  = (reg_addr == A_DAT);

        req_wr = reg_wr && hit_ctrl && reg_wdata[REQ_BIT];
        rel_wr = reg_wr && hit_ctrl && reg_wdata[REL_BIT];
        idx_wr = reg_wr && hit_idx;
        dat_wr = reg_wr && hit_dat;

        reg_rdata = 8'h00;
        if (hit_ctrl) begin
            reg_rdata[REQ_BIT] = host_own;
        end else if (hit_idx) begin
            reg_rdata = mbx_index;
        end else if (hit_dat) begin
            reg_rdata = mbx_slot_data;
        end
    end

endmodule

// File: rtl/sema_own_fsm.sv
module sema_own_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic req_wr,
    input  logic rel_wr,
    input  logic mcu_req,
    input  logic mcu_idle,
    input  logic paused,
    output logic host_own,
    output logic mcu_gnt
);
    import smbus_sema_pkg::*;

    typedef struct packed {
        own_e owner;
        logic pend;
    } own_state_t;

    own_state_t st_d, st_q;
    logic       want_host;

    always_comb begin
        st_d      = st_q;
        want_host = st_q.pend || req_wr;
        unique case (st_q.owner)
            OWN_FREE: begin
                st_d.pend = 1'b0;
                if (req_wr) begin
                    st_d.owner = OWN_HOST;
                end else if (mcu_req && !paused) begin
                    st_d.owner = OWN_MCU;
                end
            end
            OWN_HOST: begin
                st_d.pend = 1'b0;
                if (rel_wr) begin
                    st_d.owner = OWN_FREE;
                end
            end
            OWN_MCU: begin
                if (want_host && (mcu_idle || !mcu_req)) begin
                    st_d.owner = OWN_HOST;
                    st_d.pend  = 1'b0;
                end else if (!mcu_req) begin
                    st_d.owner = OWN_FREE;
                    st_d.pend  = 1'b0;
                end else begin
                    st_d.pend  = want_host;
                end
            end
            default: begin
                st_d.owner = OWN_FREE;
                st_d.pend  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{owner: OWN_FREE, pend: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign host_own = (st_q.owner == OWN_HOST);
    assign mcu_gnt  = (st_q.owner == OWN_MCU);

    assert_req_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.owner == OWN_FREE && req_wr) |=> host_own);

    assert_wait_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mcu_gnt && mcu_req && !mcu_idle) |=> !host_own);

    assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_own && rel_wr) |=> (!host_own && !mcu_gnt));

    assert_mcu_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mcu_gnt && !mcu_req) |=> !mcu_gnt);

    assert_host_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_own && !mcu_gnt && req_wr && mcu_req) |=> !mcu_gnt);

    assert_pause_block_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!mcu_gnt && paused) |=> !mcu_gnt);

endmodule

// File: rtl/sema_mailbox.sv
module sema_mailbox #(
    parameter int unsigned RESP_LAT = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic       dat_wr,
    input  logic [7:0] wdata,
    output logic [7:0] index,
    output logic [7:0] slot_data,
    output logic       paused
);
    import smbus_sema_pkg::*;

    localparam int unsigned CNT_W = $clog2(RESP_LAT + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RESP_LAT);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    typedef struct packed {
        logic [7:0]       idx;
        logic [7:0]       cmd;
        logic [7:0]       flag;
        logic [7:0]       resp;
        logic [CNT_W-1:0] cnt;
        logic             paused;
    } mbx_state_t;

    mbx_state_t mb_d, mb_q;
    logic       finish;

    always_comb begin
        mb_d   = mb_q;
        finish = (mb_q.cnt == CNT_ONE);

        if (mb_q.cnt != '0) begin
            mb_d.cnt = mb_q.cnt - CNT_ONE;
        end

        if (idx_wr) begin
            mb_d.idx = wdata;
        end

        if (dat_wr) begin
            unique case (mb_q.idx)
                SLOT_RESP: mb_d.resp = wdata;
                SLOT_FLAG: mb_d.flag = wdata;
                SLOT_CMD: begin
                    mb_d.cmd = wdata;
                    if (wdata == CODE_CMD_PAUSE) begin
                        mb_d.cnt = CNT_LOAD;
                    end
                end
                default: ;
            endcase
        end

        if (finish) begin
            mb_d.resp = CODE_DONE;
            if (mb_q.flag == CODE_ENTER) begin
                mb_d.paused = 1'b1;
            end else if (mb_q.flag == CODE_LEAVE) begin
                mb_d.paused = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mb_q <= '0;
        end else begin
            mb_q <= mb_d;
        end
    end

    always_comb begin
        unique case (mb_q.idx)
            SLOT_CMD:  slot_data = mb_q.cmd;
            SLOT_RESP: slot_data = mb_q.resp;
            SLOT_FLAG: slot_data = mb_q.flag;
            default:   slot_data = 8'h00;
        endcase
    end

    assign index  = mb_q.idx;
    assign paused = mb_q.paused;

    assert_done_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_q.cnt == CNT_ONE) |=> (mb_q.resp == CODE_DONE));

    assert_no_spurious_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!(dat_wr && mb_q.idx == SLOT_RESP) && mb_q.cnt != CNT_ONE) |=> $stable(mb_q.resp));

    assert_pause_only_at_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_q.cnt != CNT_ONE) |=> $stable(mb_q.paused));

endmodule

// File: rtl/smbus_sema_arbiter.sv
module smbus_sema_arbiter #(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned CTRL_ADR = 8,
    parameter int unsigned MBX_ADR  = 14,
    parameter int unsigned RESP_LAT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              mcu_req,
    input  logic              mcu_idle,
    output logic              mcu_gnt,
    output logic              mcu_pause
);

    logic       req_wr, rel_wr, idx_wr, dat_wr;
    logic       host_own;
    logic [7:0] mbx_index, mbx_slot_data;

    sema_reg_decode #(
        .ADDR_W  (ADDR_W),
        .CTRL_ADR(CTRL_ADR),
        .MBX_ADR (MBX_ADR)
    ) u_decode (
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .host_own     (host_own),
        .mbx_index    (mbx_index),
        .mbx_slot_data(mbx_slot_data),
        .req_wr       (req_wr),
        .rel_wr       (rel_wr),
        .idx_wr       (idx_wr),
        .dat_wr       (dat_wr),
        .reg_rdata    (reg_rdata)
    );

    sema_own_fsm u_own (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_wr  (req_wr),
        .rel_wr  (rel_wr),
        .mcu_req (mcu_req),
        .mcu_idle(mcu_idle),
        .paused  (mcu_pause),
        .host_own(host_own),
        .mcu_gnt (mcu_gnt)
    );

    sema_mailbox #(
        .RESP_LAT(RESP_LAT)
    ) u_mbx (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (idx_wr),
        .dat_wr   (dat_wr),
        .wdata    (reg_wdata),
        .index    (mbx_index),
        .slot_data(mbx_slot_data),
        .paused   (mcu_pause)
    );

    assert_never_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_own && mcu_gnt));

endmodule

// File: tb/smbus_sema_arbiter_bench.sv
module smbus_sema_arbiter_bench;

    localparam int LAT = 4;
    localparam logic [3:0] A_CTRL = 4'd8;
    localparam logic [3:0] A_IDX  = 4'd14;
    localparam logic [3:0] A_DAT  = 4'd15;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [3:0] reg_addr = 4'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       mcu_req = 1'b0;
    logic       mcu_idle = 1'b0;
    logic       mcu_gnt, mcu_pause;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    smbus_sema_arbiter #(.RESP_LAT(LAT)) u_smbus_sema_arbiter (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mcu_req(mcu_req),
        .mcu_idle(mcu_idle), .mcu_gnt(mcu_gnt), .mcu_pause(mcu_pause)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; reg_wr = 1'b0; mcu_req = 1'b0; mcu_idle = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    function automatic int host_bit();
        return int'(reg_rdata[4]);
    endfunction

    task automatic mbx_put(input logic [7:0] slot, input logic [7:0] val);
        wr(A_IDX, slot);
        wr(A_DAT, val);
    endtask

    logic [7:0] v;

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        rd(A_CTRL, v); check("R1 ctrl", v, 0);
        check("R1 gnt", mcu_gnt, 0);
        check("R1 pause", mcu_pause, 0);
        wr(A_IDX, 8'h82); rd(A_DAT, v); check("R1 resp", v, 0);
        wr(A_IDX, 8'h83); rd(A_DAT, v); check("R1 flag", v, 0);

        // ownership sweep: start owner x {rel,req} x mcu_req x mcu_idle
        for (int s = 0; s < 3; s++) begin
            for (int c = 0; c < 4; c++) begin
                for (int m = 0; m < 4; m++) begin
                    int exp_host, exp_gnt;
                    bit b_req, b_rel, m_req, m_idle;
                    string tag;
                    b_req = c[0]; b_rel = c[1]; m_req = m[0]; m_idle = m[1];
                    do_reset();
                    if (s == 1) begin
                        reg_addr = A_CTRL; wr(A_CTRL, 8'h10);
                    end else if (s == 2) begin
                        mcu_req = 1'b1; @(negedge clk);
                    end
                    exp_host = 0; exp_gnt = 0;
                    if (s == 0) begin
                        tag = "R2/R6/R7 free";
                        if (b_req) exp_host = 1;
                        else if (m_req) exp_gnt = 1;
                    end else if (s == 1) begin
                        tag = "R4/R5 host";
                        exp_host = b_rel ? 0 : 1;
                    end else begin
                        tag = "R3/R5/R6 mcu";
                        if (b_req && (m_idle || !m_req)) exp_host = 1;
                        else if (m_req) exp_gnt = 1;
                    end
                    mcu_req = m_req; mcu_idle = m_idle;
                    wr(A_CTRL, {2'b00, b_rel, b_req, 4'h0});
                    rd(A_CTRL, v);
                    check(tag, host_bit(), exp_host);
                    check(tag, mcu_gnt, exp_gnt);
                end
            end
        end

        // R3 pending request held across busy cycles
        do_reset();
        mcu_req = 1'b1; @(negedge clk);
        wr(A_CTRL, 8'h10);
        for (int k = 0; k < 3; k++) begin
            rd(A_CTRL, v);
            check("R3 pending bit4", host_bit(), 0);
            check("R3 pending gnt", mcu_gnt, 1);
            @(negedge clk);
        end
        mcu_idle = 1'b1; @(negedge clk); mcu_idle = 1'b0;
        rd(A_CTRL, v);
        check("R3 handover bit4", host_bit(), 1);
        check("R3 handover gnt", mcu_gnt, 0);

        // R5 release by non-owner while mcu owns
        do_reset();
        mcu_req = 1'b1; @(negedge clk);
        wr(A_CTRL, 8'h20);
        rd(A_CTRL, v);
        check("R5 foreign release gnt", mcu_gnt, 1);
        check("R5 foreign release bit4", host_bit(), 0);
        mcu_req = 1'b0; @(negedge clk);
        // R5 repeated request while owning
        wr(A_CTRL, 8'h10); wr(A_CTRL, 8'h10);
        rd(A_CTRL, v); check("R5 re-request", host_bit(), 1);
        wr(A_CTRL, 8'h20);
        rd(A_CTRL, v); check("R4 release", host_bit(), 0);

        // R8 mailbox addressing
        do_reset();
        mbx_put(8'h83, 8'h5A);
        rd(A_IDX, v); check("R8 index readback", v, 8'h83);
        rd(A_DAT, v); check("R8 flag slot", v, 8'h5A);
        mbx_put(8'h81, 8'h33);
        rd(A_DAT, v); check("R8 unmapped slot", v, 0);
        wr(A_IDX, 8'h83); rd(A_DAT, v); check("R8 flag kept", v, 8'h5A);

        // R9 / R10 pause enter with exact latency
        mbx_put(8'h82, 8'h00);
        mbx_put(8'h83, 8'hB4);
        wr(A_IDX, 8'h80);
        wr(A_DAT, 8'h96);
        wr(A_IDX, 8'h82);
        for (int k = 1; k < LAT; k++) begin
            rd(A_DAT, v); check("R9 early resp", v, 0);
            check("R10 early pause", mcu_pause, 0);
            @(negedge clk);
        end
        rd(A_DAT, v); check("R9 resp at latency", v, 8'hFA);
        check("R10 pause entered", mcu_pause, 1);

        // R12 paused: mcu not granted, host still is
        mcu_req = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R12 paused gnt", mcu_gnt, 0);
        end
        wr(A_CTRL, 8'h10);
        rd(A_CTRL, v); check("R12 host while paused", host_bit(), 1);
        mcu_req = 1'b0;
        wr(A_CTRL, 8'h20);

        // R11 wrong command: no response, pause unchanged
        mbx_put(8'h82, 8'h00);
        mbx_put(8'h83, 8'hB5);
        mbx_put(8'h80, 8'h55);
        repeat (3 * LAT) @(negedge clk);
        rd(A_DAT, v); check("R11 cmd stored", v, 8'h55);
        wr(A_IDX, 8'h82); rd(A_DAT, v); check("R11 no resp", v, 0);
        check("R11 pause kept", mcu_pause, 1);

        // R10 pause leave
        mbx_put(8'h80, 8'h96);
        wr(A_IDX, 8'h82);
        repeat (LAT) @(negedge clk);
        rd(A_DAT, v); check("R9 resp leave", v, 8'hFA);
        check("R10 pause left", mcu_pause, 0);

        // R6 grant works again after unpause
        mcu_req = 1'b1; @(negedge clk);
        check("R6 grant after unpause", mcu_gnt, 1);
        mcu_req = 1'b0; @(negedge clk);
        check("R6 drop", mcu_gnt, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule